// File: doc/BRIEF.md
# Audio Port Control/Status Registers with Set and Clear Aliases

This block holds the control and status registers of a serial audio port behind a simple 32-bit register bus. Each of the two registers answers at three addresses: a plain one that overwrites the register, one where every 1 in the write data sets the matching bit, and one where every 1 clears it. Software can therefore flip single bits, such as the run bit or a sticky error flag, without a read-modify-write.

The control register carries a soft-reset bit and a clock-gate bit, both set out of reset. While soft reset is set, every other field and both sticky flags are held at zero. While the gate is set, only those two bits accept writes. The status register shows a live busy input and two sticky FIFO error flags, one for underflow and one for overflow, which are set by event pulses. A FIFO-error enable bit decides whether the flags drive the interrupt output. The audio datapath and its clocks sit outside. The block only exports the control fields and takes in the events.

Top module: `aud_csr_alias`

## Requirements
- R1: After reset the control register reads 0xC000_0000 (bit 31 soft reset and bit 30 clock gate set, all else 0), both sticky flags are 0 and irq_o is 0.
- R2: A write to offset 0x0 of a register replaces it. Only control bits 31, 30, 16, 14:8 and 6:0 are stored. All other control bits read 0.
- R3: A write to offset 0x4 sets every stored bit whose write-data bit is 1 and leaves the others unchanged.
- R4: A write to offset 0x8 clears every stored bit whose write-data bit is 1 and leaves the others unchanged.
- R5: While the clock-gate bit (30) is 1, writes still change bits 31 and 30 but leave every other control bit and both status flags unchanged. Whether a write is blocked is decided by the register state before that write.
- R6: Whenever the soft-reset bit (31) is 1, every control bit other than 31 and 30 and both sticky flags read 0. While soft reset is 1, writes to those fields and events have no effect.
- R7: The control register sits at 0x00–0x0F and the status register at 0x10–0x1F (address bit 4). A read returns its data in bus_rdata one cycle after bus_rd. Offsets 0x0, 0x4, 0x8 and 0xC of a register read the same value. A write to offset 0xC is ignored. An access with address bits 1:0 nonzero or with any bit above bit 4 set reads 0 and writes nothing.
- R8: Status bit 1 (underflow) and bit 2 (overflow) are set by a one-cycle pulse on uf_evt_i or of_evt_i. They stay set until written 0 through offset 0x0 or cleared through offset 0x8 of the status register. A write of 1 through offset 0x0 or 0x4 also sets them.
- R9: If an event and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R10: irq_o is 1 exactly when control bit 16 is 1 and at least one sticky flag is 1.
- R11: run_o follows control bit 0, and ctrl_o shows the whole control register. Status bit 0 shows busy_i at the read cycle and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, data returned next cycle |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| busy_i | input | 1 | Live busy indication from the port |
| uf_evt_i | input | 1 | FIFO underflow event pulse |
| of_evt_i | input | 1 | FIFO overflow event pulse |
| ctrl_o | output | 32 | Current control register |
| run_o | output | 1 | Run field |
| irq_o | output | 1 | FIFO error interrupt |

## Verification
The hardest situations to reach are the ones where two rules meet in one cycle. Examples are an event pulse landing on the same edge as a status clear, a plain write that clears the gate while also writing other fields, and a set of soft reset while the gate is held. The directed sequence walks the block through reset, gated, open and soft-reset states and forces each collision on purpose. The event pulse and the bus write are driven in the same cycle. Afterwards a long random phase runs with soft reset biased to stay clear. It mixes all alias addresses, stray addresses, reads and event pulses, and a behavioural model is compared against the outputs on every clock.

// File: rtl/aud_csr_pkg.sv
package aud_csr_pkg;

  localparam int unsigned CSR_W = 32;

  // Alias selected by address bits 3:2
  typedef enum logic [1:0] {
    AL_BASE = 2'd0,
    AL_SET  = 2'd1,
    AL_CLR  = 2'd2,
    AL_HOLE = 2'd3
  } alias_e;

  // Control field positions
  localparam int unsigned B_RUN     = 0;
  localparam int unsigned B_CAPTURE = 1;
  localparam int unsigned B_FOLLOW  = 2;
  localparam int unsigned B_DELAY   = 3;
  localparam int unsigned B_JUSTIFY = 4;
  localparam int unsigned B_FRMPOL  = 5;
  localparam int unsigned B_EDGE    = 6;
  localparam int unsigned B_WLEN    = 8;
  localparam int unsigned WLEN_W    = 2;
  localparam int unsigned B_WIDE48  = 10;
  localparam int unsigned B_BASE384 = 11;
  localparam int unsigned B_MULT    = 12;
  localparam int unsigned MULT_W    = 3;
  localparam int unsigned B_IRQEN   = 16;
  localparam int unsigned B_CGATE   = 30;
  localparam int unsigned B_SRST    = 31;

  function automatic logic [CSR_W-1:0] field_mask(input int unsigned lo, input int unsigned w);
    logic [CSR_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < w; i++) m[lo+i] = 1'b1;
    return m;
  endfunction

  localparam logic [CSR_W-1:0] CTRL_KEEP = field_mask(B_SRST, 1) | field_mask(B_CGATE, 1);
  localparam logic [CSR_W-1:0] CTRL_IMPL = CTRL_KEEP
                                         | field_mask(B_RUN, B_EDGE + 1)
                                         | field_mask(B_WLEN, WLEN_W)
                                         | field_mask(B_WIDE48, 1)
                                         | field_mask(B_BASE384, 1)
                                         | field_mask(B_MULT, MULT_W)
                                         | field_mask(B_IRQEN, 1);
  localparam logic [CSR_W-1:0] CTRL_GUARD = CTRL_IMPL & ~CTRL_KEEP;
  localparam logic [CSR_W-1:0] CTRL_RST   = CTRL_KEEP;

  // Status field positions
  localparam int unsigned ST_BUSY  = 0;
  localparam int unsigned ST_FLAG0 = 1;
  localparam int unsigned N_FLAGS  = 2;

  // Merge of a write into the old value according to the alias
  function automatic logic [CSR_W-1:0] alias_apply(input logic [CSR_W-1:0] old_v,
                                                   input logic [CSR_W-1:0] wr_v,
                                                   input alias_e k);
    unique case (k)
      AL_BASE: return wr_v;
      AL_SET:  return old_v | wr_v;
      AL_CLR:  return old_v & ~wr_v;
      default: return old_v;
    endcase
  endfunction

  function automatic logic [N_FLAGS-1:0] flag_apply(input logic [N_FLAGS-1:0] old_v,
                                                    input logic [N_FLAGS-1:0] wr_v,
                                                    input alias_e k);
    unique case (k)
      AL_BASE: return wr_v;
      AL_SET:  return old_v | wr_v;
      AL_CLR:  return old_v & ~wr_v;
      default: return old_v;
    endcase
  endfunction

endpackage

// File: rtl/aud_csr_decode.sv
module aud_csr_decode
  import aud_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic              hit,
  output logic              stat_sel,
  output logic              ctrl_wr,
  output logic              stat_wr,
  output alias_e            kind
);
  localparam int unsigned SEL_BIT = 4;

  logic upper_zero;

  generate
    if (ADDR_W > SEL_BIT + 1) begin : g_upper
      assign upper_zero = (addr[ADDR_W-1:SEL_BIT+1] == '0);
    end else begin : g_noupper
      assign upper_zero = 1'b1;
    end
  endgenerate

  assign hit      = upper_zero && (addr[1:0] == 2'b00);
  assign stat_sel = addr[SEL_BIT];
  assign kind     = alias_e'(addr[3:2]);
  assign ctrl_wr  = wr && hit && !stat_sel;
  assign stat_wr  = wr && hit && stat_sel;

endmodule

// File: rtl/aud_csr_ctrl.sv
module aud_csr_ctrl
  import aud_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  alias_e           kind,
  input  logic [CSR_W-1:0] wdata,
  output logic [CSR_W-1:0] ctrl_q,
  output logic             srst_nxt,
  output logic             wr_open
);
  logic [CSR_W-1:0] cand;
  logic [CSR_W-1:0] nxt;

  assign wr_open = !ctrl_q[B_SRST] && !ctrl_q[B_CGATE];
  assign cand    = alias_apply(ctrl_q, wdata, kind) & CTRL_IMPL;

  always_comb begin
    nxt = ctrl_q;
    if (wr) begin
      nxt = (nxt & ~CTRL_KEEP) | (cand & CTRL_KEEP);
      if (wr_open) nxt = (nxt & ~CTRL_GUARD) | (cand & CTRL_GUARD);
    end
    if (nxt[B_SRST]) nxt = nxt & ~CTRL_GUARD;
  end

  assign srst_nxt = nxt[B_SRST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= CTRL_RST;
    else        ctrl_q <= nxt;
  end

  // R6
  srst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[B_SRST] |-> ((ctrl_q & CTRL_GUARD) == '0));

  // R5
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[B_CGATE] && !srst_nxt) |=> ((ctrl_q & CTRL_GUARD) == ($past(ctrl_q) & CTRL_GUARD)));

endmodule

// File: rtl/aud_csr_status.sv
module aud_csr_status
  import aud_csr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  alias_e             kind,
  input  logic [N_FLAGS-1:0] wbits,
  input  logic               wr_open,
  input  logic               srst_nxt,
  input  logic [N_FLAGS-1:0] evt,
  output logic [N_FLAGS-1:0] flag_q
);
  logic [N_FLAGS-1:0] fcand;
  logic [N_FLAGS-1:0] clr_wr;

  assign fcand = flag_apply(flag_q, wbits, kind);

  generate
    for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
      assign clr_wr[i] = wr && wr_open && !fcand[i];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              flag_q[i] <= 1'b0;
        else if (srst_nxt)       flag_q[i] <= 1'b0;
        else if (evt[i])         flag_q[i] <= 1'b1;
        else if (wr && wr_open)  flag_q[i] <= fcand[i];
      end

      // R9
      evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[i] && !srst_nxt) |=> flag_q[i]);

      // R8
      sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[i] && !clr_wr[i] && !srst_nxt) |=> flag_q[i]);
    end
  endgenerate

endmodule

// File: rtl/aud_csr_alias.sv
module aud_csr_alias
  import aud_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CSR_W-1:0]  bus_wdata,
  output logic [CSR_W-1:0]  bus_rdata,
  input  logic              busy_i,
  input  logic              uf_evt_i,
  input  logic              of_evt_i,
  output logic [CSR_W-1:0]  ctrl_o,
  output logic              run_o,
  output logic              irq_o
);
  logic               hit;
  logic               stat_sel;
  logic               ctrl_wr;
  logic               stat_wr;
  alias_e             kind;
  logic [CSR_W-1:0]   ctrl_q;
  logic               srst_nxt;
  logic               wr_open;
  logic [N_FLAGS-1:0] flag_q;
  logic [CSR_W-1:0]   stat_view;

  aud_csr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr     (bus_addr),
    .wr       (bus_wr),
    .hit      (hit),
    .stat_sel (stat_sel),
    .ctrl_wr  (ctrl_wr),
    .stat_wr  (stat_wr),
    .kind     (kind)
  );

  aud_csr_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (ctrl_wr),
    .kind     (kind),
    .wdata    (bus_wdata),
    .ctrl_q   (ctrl_q),
    .srst_nxt (srst_nxt),
    .wr_open  (wr_open)
  );

  aud_csr_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (stat_wr),
    .kind     (kind),
    .wbits    (bus_wdata[ST_FLAG0 +: N_FLAGS]),
    .wr_open  (wr_open),
    .srst_nxt (srst_nxt),
    .evt      ({of_evt_i, uf_evt_i}),
    .flag_q   (flag_q)
  );

  always_comb begin
    stat_view                       = '0;
    stat_view[ST_BUSY]              = busy_i;
    stat_view[ST_FLAG0 +: N_FLAGS]  = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= !hit ? '0 : (stat_sel ? stat_view : ctrl_q);
  end

  assign ctrl_o = ctrl_q;
  assign run_o  = ctrl_q[B_RUN];
  assign irq_o  = ctrl_q[B_IRQEN] && (|flag_q);

  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  // R10
  srst_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[B_SRST] |-> !irq_o);

endmodule

// File: tb/aud_csr_alias_tb.sv
module aud_csr_alias_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        busy_i = 1'b0;
  logic        uf_evt_i = 1'b0;
  logic        of_evt_i = 1'b0;
  logic [31:0] ctrl_o;
  logic        run_o;
  logic        irq_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit armed  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  aud_csr_alias #(.ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy_i(busy_i), .uf_evt_i(uf_evt_i), .of_evt_i(of_evt_i),
    .ctrl_o(ctrl_o), .run_o(run_o), .irq_o(irq_o)
  );

  // ---------------- reference model ----------------
  localparam logic [31:0] STORED = 32'hC001_7F7F;
  logic [31:0] m_ctrl;
  logic        m_uf, m_of;
  logic [31:0] m_rdata;

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] w, input int k);
    if (k == 0) return w;
    if (k == 1) return o | w;
    if (k == 2) return o & ~w;
    return o;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 32'hC000_0000; m_uf = 0; m_of = 0; m_rdata = 0;
    end else begin
      logic [31:0] nc, tgt, st;
      logic nuf, nof, ok_addr, open;
      int k;
      ok_addr = (bus_addr[1:0] == 0) && (bus_addr[7:5] == 0);
      k = int'(bus_addr[3:2]);
      if (bus_rd) begin
        if (!ok_addr) m_rdata = 0;
        else if (bus_addr[4]) m_rdata = {29'd0, m_of, m_uf, busy_i};
        else m_rdata = m_ctrl;
      end
      open = !m_ctrl[31] && !m_ctrl[30];
      nc = m_ctrl; nuf = m_uf; nof = m_of;
      if (bus_wr && ok_addr && !bus_addr[4]) begin
        tgt = merge(m_ctrl, bus_wdata, k) & STORED;
        nc[31] = tgt[31]; nc[30] = tgt[30];
        if (open) for (int b = 0; b < 30; b++) nc[b] = tgt[b];
      end
      if (bus_wr && ok_addr && bus_addr[4] && open) begin
        st = merge({29'd0, m_of, m_uf, 1'b0}, bus_wdata, k);
        nuf = st[1]; nof = st[2];
      end
      if (uf_evt_i) nuf = 1;
      if (of_evt_i) nof = 1;
      if (nc[31]) begin nc = nc & 32'hC000_0000; nuf = 0; nof = 0; end
      m_ctrl = nc; m_uf = nuf; m_of = nof;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && armed) begin
      chk("R2/R3/R4/R5/R6 model ctrl_o", ctrl_o, m_ctrl);
      chk("R11 model run_o", {31'd0, run_o}, {31'd0, m_ctrl[0]});
      chk("R10 model irq_o", {31'd0, irq_o}, {31'd0, m_ctrl[16] & (m_uf | m_of)});
      chk("R7 model bus_rdata", bus_rdata, m_rdata);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic pulse(input logic uf, input logic of);
    @(negedge clk); uf_evt_i = uf; of_evt_i = of;
    @(negedge clk); uf_evt_i = 0; of_evt_i = 0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    armed = 1;
    chk("R1 reset ctrl", ctrl_o, 32'hC000_0000);
    chk("R1 reset irq", {31'd0, irq_o}, 32'd0);
    rd_reg(8'h10, d); chk("R1 reset status", d, 32'd0);

    wr_reg(8'h00, 32'hC001_0001); chk("R5 gated base write", ctrl_o, 32'hC000_0000);
    wr_reg(8'h08, 32'h4000_0000); chk("R4 clear gate only", ctrl_o, 32'h8000_0000);
    wr_reg(8'h04, 32'h0000_0001); chk("R6 run held in soft reset", ctrl_o, 32'h8000_0000);
    pulse(1, 0);
    rd_reg(8'h10, d); chk("R6 event ignored in soft reset", d, 32'd0);
    wr_reg(8'h08, 32'h8000_0000); chk("R4 clear soft reset", ctrl_o, 32'd0);

    wr_reg(8'h00, 32'h3FFF_FFFF); chk("R2 base write stored bits", ctrl_o, 32'h0001_7F7F);
    chk("R11 run follows bit0", {31'd0, run_o}, 32'd1);
    wr_reg(8'h08, 32'h0000_0F0F); chk("R4 clear alias", ctrl_o, 32'h0001_7070);
    chk("R11 run low", {31'd0, run_o}, 32'd0);
    wr_reg(8'h04, 32'h0000_0003); chk("R3 set alias", ctrl_o, 32'h0001_7073);

    wr_reg(8'h04, 32'h4000_0000); chk("R3 set gate", ctrl_o, 32'h4001_7073);
    wr_reg(8'h00, 32'h4000_0000); chk("R5 gate blocks fields", ctrl_o, 32'h4001_7073);
    pulse(1, 0);
    chk("R10 irq with flag and enable", {31'd0, irq_o}, 32'd1);
    wr_reg(8'h18, 32'h0000_0002);
    rd_reg(8'h10, d); chk("R5 gated status clear ignored", d, 32'h0000_0002);
    wr_reg(8'h08, 32'h4000_0000); chk("R4 ungate", ctrl_o, 32'h0001_7073);
    wr_reg(8'h18, 32'h0000_0002);
    rd_reg(8'h10, d); chk("R8 clear alias clears underflow", d, 32'd0);
    chk("R10 irq drops", {31'd0, irq_o}, 32'd0);

    @(negedge clk); bus_addr = 8'h18; bus_wdata = 32'h4; bus_wr = 1; of_evt_i = 1;
    @(negedge clk); bus_wr = 0; of_evt_i = 0;
    rd_reg(8'h10, d); chk("R9 event beats clear", d, 32'h0000_0004);
    wr_reg(8'h18, 32'h0000_0004);
    rd_reg(8'h10, d); chk("R8 overflow cleared", d, 32'd0);

    pulse(1, 0);
    repeat (5) @(negedge clk);
    rd_reg(8'h10, d); chk("R8 underflow sticky", d, 32'h0000_0002);
    wr_reg(8'h08, 32'h0001_0000);
    chk("R10 irq masked", {31'd0, irq_o}, 32'd0);
    chk("R4 enable cleared", ctrl_o, 32'h0000_7073);
    wr_reg(8'h14, 32'h0000_0004);
    rd_reg(8'h10, d); chk("R8 set alias sets overflow", d, 32'h0000_0006);
    wr_reg(8'h10, 32'h0000_0000);
    rd_reg(8'h10, d); chk("R2 status base write", d, 32'd0);

    busy_i = 1;
    rd_reg(8'h10, d); chk("R11 busy visible", d, 32'h0000_0001);
    wr_reg(8'h10, 32'h0000_0000);
    rd_reg(8'h10, d); chk("R11 busy ignores write", d, 32'h0000_0001);
    busy_i = 0;
    rd_reg(8'h10, d); chk("R11 busy low", d, 32'd0);

    rd_reg(8'h00, d); chk("R7 read base", d, 32'h0000_7073);
    rd_reg(8'h04, d); chk("R7 read set alias", d, 32'h0000_7073);
    rd_reg(8'h08, d); chk("R7 read clear alias", d, 32'h0000_7073);
    rd_reg(8'h0C, d); chk("R7 read hole", d, 32'h0000_7073);
    wr_reg(8'h0C, 32'hFFFF_FFFF); chk("R7 hole write ignored", ctrl_o, 32'h0000_7073);
    rd_reg(8'h01, d); chk("R7 misaligned read", d, 32'd0);
    rd_reg(8'h20, d); chk("R7 out of range read", d, 32'd0);
    wr_reg(8'h20, 32'hFFFF_FFFF); chk("R7 out of range write", ctrl_o, 32'h0000_7073);

    pulse(1, 0);
    wr_reg(8'h04, 32'h8000_0000); chk("R6 soft reset clears fields", ctrl_o, 32'h8000_0000);
    rd_reg(8'h10, d); chk("R6 soft reset clears flags", d, 32'd0);
    wr_reg(8'h08, 32'hC000_0000); chk("R4 leave soft reset", ctrl_o, 32'd0);

    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      bus_wr    = ($urandom % 3) == 0;
      bus_rd    = ($urandom % 3) == 0;
      bus_addr  = (($urandom % 10) == 0) ? 8'($urandom) : {3'd0, 1'($urandom), 2'($urandom), 2'd0};
      bus_wdata = $urandom;
      if (($urandom % 8) != 0) bus_wdata[31] = 1'b0;
      if (($urandom % 3) != 0) bus_wdata[30] = 1'b0;
      busy_i    = 1'($urandom);
      uf_evt_i  = ($urandom % 7) == 0;
      of_evt_i  = ($urandom % 7) == 0;
    end
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; uf_evt_i = 0; of_evt_i = 0;
    repeat (3) @(negedge clk);

    done = 1;
    summary();
    $finish;
  end

endmodule